// File: doc/BRIEF.md
# Edge-Triggered Channel Power-Saving Controller

This block manages power for a single radio channel, transmit or receive, between bursts of activity. It watches the channel's enable input. When that input falls, it switches off a group of power domains, and the size of the group depends on a programmed power-down level. When the input rises, it switches every domain that is off back on, one at a time, and then raises a ready flag that tells the rest of the channel it may run.

There are three domains: the channel regulators, the channel RF PLL and the signal datapath (mixer, converters, filters). Each domain has its own enable output and its own settle delay, given in clock cycles on a delay input. The levels are cumulative. Level 0 switches off only the datapath and gives the shortest recovery. Level 1 also switches off the PLL. Level 2 also switches off the regulators, so it saves the most power and takes the longest to recover.

The level is written through a small configuration port. A value outside 0 to 2 is rejected, and this also raises a sticky error flag. A busy output reports that a sequence is running.

Top module: `chan_pwr_ctrl`

## Requirements
- R1: After reset, reg_en=1, pll_en=1, dp_en=0, ready=0, busy=0, cfg_err=0 and level_out=0.
- R2: A write with cfg_wr=1 and cfg_level in 0..2 sets level_out to that value on the next cycle.
- R3: A write with cfg_level of 3 or more sets cfg_err and forces level_out to 0. cfg_err stays set through later legal writes and is cleared only by reset.
- R4: A falling edge on chan_en gates a set of domains chosen by the level held when the edge is seen: level 0 gates the datapath only, level 1 gates the datapath and PLL, level 2 gates all three. A domain outside the set keeps its enable.
- R5: Power-down switches domains off in the order datapath, PLL, regulators, skipping domains that are already off. After one domain is switched off, the next one follows dly+1 cycles later, where dly is the delay input of the domain just switched off.
- R6: A rising edge on chan_en switches on every domain that is off, in the order regulators, PLL, datapath. The spacing between steps is dly+1 cycles of the domain just switched on.
- R7: ready rises dly+1 cycles after the last domain was switched on, where dly is that domain's delay. ready is never high while any domain enable is low.
- R8: ready goes low on the clock edge at which the falling edge of chan_en is detected.
- R9: A rising edge that arrives during power-down abandons the remaining power-down steps and starts power-up from the enables as they stand at that moment.
- R10: A falling edge that arrives during power-up abandons power-up and starts power-down from the current enables. ready stays low.
- R11: busy is high exactly while a power-down or power-up sequence is still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel enable; its edges start the sequences |
| cfg_wr | input | 1 | Write strobe for the power-down level |
| cfg_level | input | LVL_W | Requested power-down level |
| dly_reg | input | CNT_W | Settle delay of the regulator domain, in cycles |
| dly_pll | input | CNT_W | Settle or recovery delay of the PLL domain, in cycles |
| dly_dp | input | CNT_W | Settle delay of the datapath domain, in cycles |
| reg_en | output | 1 | Regulator domain enable |
| pll_en | output | 1 | PLL domain enable |
| dp_en | output | 1 | Datapath domain enable |
| ready | output | 1 | Channel fully powered and usable |
| busy | output | 1 | A sequence is in progress |
| cfg_err | output | 1 | Sticky flag for an illegal level write |
| level_out | output | 2 | Level currently in force |

## Verification
The bench counts the cycles from a rising edge to ready at each level and with two sets of delays. A design that spaced its steps wrongly, or that let ready rise before the last settle delay ran out, would miss the expected count. It reverses chan_en in the middle of both power-down and power-up. A design that finished the old sequence, or that restarted from the reset state instead of the current enables, would show the wrong enables on the following cycles. It writes an illegal level and then a legal one, and a design that dropped the error or kept the illegal level would be caught. At level 0 and level 1 it checks that the domains outside the gated set stay on.

// File: rtl/cps_pkg.sv
package cps_pkg;

    localparam int unsigned NDOM  = 3;
    localparam int unsigned DOM_REG = 0;
    localparam int unsigned DOM_PLL = 1;
    localparam int unsigned DOM_DP  = 2;
    localparam logic [1:0]  MAX_LEVEL = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } seq_st_e;

    // Domains gated for a given level; cumulative from the datapath upward.
    function automatic logic [NDOM-1:0] level_mask(input logic [1:0] lvl);
        logic [NDOM-1:0] m;
        m          = '0;
        m[DOM_DP]  = 1'b1;
        m[DOM_PLL] = (lvl >= 2'd1);
        m[DOM_REG] = (lvl >= 2'd2);
        return m;
    endfunction

endpackage

// File: rtl/cps_edge.sv
module cps_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise,
    output logic fall
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = sig_in & ~prev_q;
    assign fall = ~sig_in & prev_q;

endmodule

// File: rtl/cps_cfg.sv
module cps_cfg
    import cps_pkg::*;
#(
    parameter int unsigned LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [LVL_W-1:0] level_in,
    output logic [1:0]       level,
    output logic             err,
    output logic [NDOM-1:0]  gate_mask
);

    typedef struct packed {
        logic [1:0] lvl;
        logic       err;
    } cfg_t;

    cfg_t d, q;
    logic illegal;

    assign illegal = (level_in > LVL_W'(MAX_LEVEL));

    always_comb begin
        d = q;
        if (wr) begin
            if (illegal) begin
                d.err = 1'b1;
                d.lvl = 2'd0;
            end else begin
                d.lvl = level_in[1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{lvl: 2'd0, err: 1'b0};
        else        q <= d;
    end

    assign level     = q.lvl;
    assign err       = q.err;
    assign gate_mask = level_mask(q.lvl);

    p_legal_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !illegal) |=> (level == $past(level_in[1:0])));
    p_illegal_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && illegal) |=> (err && level == 2'd0));
    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    p_level_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= MAX_LEVEL);

endmodule

// File: rtl/cps_seq.sv
module cps_seq
    import cps_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rise,
    input  logic                       fall,
    input  logic [NDOM-1:0]            gate_mask,
    input  logic [NDOM-1:0][CNT_W-1:0] dly,
    output logic [NDOM-1:0]            dom_on,
    output logic                       ready,
    output logic                       busy
);

    typedef struct packed {
        seq_st_e          st;
        logic [NDOM-1:0]  on;
        logic [CNT_W-1:0] cnt;
        logic [NDOM-1:0]  mask;
        logic             ready;
    } seq_t;

    seq_t d, q;

    always_comb begin
        logic            do_up;
        logic            do_down;
        logic            found;
        logic [NDOM-1:0] msk;
        d       = q;
        do_up   = 1'b0;
        do_down = 1'b0;
        found   = 1'b0;
        msk     = q.mask;

        if (fall) begin
            d.ready = 1'b0;
            d.mask  = gate_mask;
            msk     = gate_mask;
            do_down = 1'b1;
        end else if (rise) begin
            d.ready = 1'b0;
            do_up   = 1'b1;
        end else if (q.st != ST_IDLE) begin
            if (q.cnt != '0)          d.cnt   = q.cnt - 1'b1;
            else if (q.st == ST_UP)   do_up   = 1'b1;
            else                      do_down = 1'b1;
        end

        // Power-up: lowest-index domain that is off goes first.
        if (do_up) begin
            d.st    = ST_IDLE;
            d.ready = 1'b1;
            for (int i = 0; i < int'(NDOM); i++) begin
                if (!found && !q.on[i]) begin
                    found   = 1'b1;
                    d.on[i] = 1'b1;
                    d.cnt   = dly[i];
                    d.st    = ST_UP;
                    d.ready = 1'b0;
                end
            end
        end

        // Power-down: highest-index gated domain that is on goes first.
        if (do_down) begin
            d.st = ST_IDLE;
            for (int i = int'(NDOM) - 1; i >= 0; i--) begin
                if (!found && msk[i] && q.on[i]) begin
                    found   = 1'b1;
                    d.on[i] = 1'b0;
                    d.cnt   = dly[i];
                    d.st    = ST_DOWN;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.on    <= NDOM'(3'b011);
            q.cnt   <= '0;
            q.mask  <= '0;
            q.ready <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign dom_on = q.on;
    assign ready  = q.ready;
    assign busy   = (q.st != ST_IDLE);

    // Checker state: marks that $past refers to a cycle after reset.
    logic past_vld_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_vld_q <= 1'b0;
        else        past_vld_q <= 1'b1;
    end

    p_ready_all_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (&dom_on));
    p_fall_drops_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !ready);
    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ready);
    p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        past_vld_q |-> ($countones(dom_on ^ $past(dom_on)) <= 1));
    p_up_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_vld_q && $rose(dom_on[DOM_DP])) |-> (dom_on[DOM_REG] && dom_on[DOM_PLL]));
    p_down_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_vld_q && $fell(dom_on[DOM_REG])) |-> (!dom_on[DOM_PLL] && !dom_on[DOM_DP]));

    for (genvar g = 0; g < int'(NDOM); g++) begin : g_scope
        p_gate_scope_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (past_vld_q && $fell(dom_on[g])) |-> q.mask[g]);
    end

endmodule

// File: rtl/chan_pwr_ctrl.sv
module chan_pwr_ctrl
    import cps_pkg::*;
#(
    parameter int unsigned LVL_W = 2,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             cfg_wr,
    input  logic [LVL_W-1:0] cfg_level,
    input  logic [CNT_W-1:0] dly_reg,
    input  logic [CNT_W-1:0] dly_pll,
    input  logic [CNT_W-1:0] dly_dp,
    output logic             reg_en,
    output logic             pll_en,
    output logic             dp_en,
    output logic             ready,
    output logic             busy,
    output logic             cfg_err,
    output logic [1:0]       level_out
);

    logic                       rise, fall;
    logic [NDOM-1:0]            gate_mask;
    logic [NDOM-1:0][CNT_W-1:0] dly;
    logic [NDOM-1:0]            dom_on;

    assign dly = {dly_dp, dly_pll, dly_reg};

    cps_edge i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (chan_en),
        .rise   (rise),
        .fall   (fall)
    );

    cps_cfg #(.LVL_W(LVL_W)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .level_in  (cfg_level),
        .level     (level_out),
        .err       (cfg_err),
        .gate_mask (gate_mask)
    );

    cps_seq #(.CNT_W(CNT_W)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .fall      (fall),
        .gate_mask (gate_mask),
        .dly       (dly),
        .dom_on    (dom_on),
        .ready     (ready),
        .busy      (busy)
    );

    assign reg_en = dom_on[DOM_REG];
    assign pll_en = dom_on[DOM_PLL];
    assign dp_en  = dom_on[DOM_DP];

endmodule

// File: tb/test_chan_pwr_ctrl.sv
`timescale 1ns/1ps
module test_chan_pwr_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_en = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_level = 2'd0;
    logic [3:0] dly_reg = 4'd3;
    logic [3:0] dly_pll = 4'd5;
    logic [3:0] dly_dp = 4'd2;
    logic       reg_en, pll_en, dp_en, ready, busy, cfg_err;
    logic [1:0] level_out;

    chan_pwr_ctrl #(.LVL_W(2), .CNT_W(4)) i_chan_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cfg_wr(cfg_wr),
        .cfg_level(cfg_level), .dly_reg(dly_reg), .dly_pll(dly_pll), .dly_dp(dly_dp),
        .reg_en(reg_en), .pll_en(pll_en), .dp_en(dp_en), .ready(ready),
        .busy(busy), .cfg_err(cfg_err), .level_out(level_out)
    );

    always #5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";

    // Behavioural reference model
    int m_reg = 1, m_pll = 1, m_dp = 0, m_ready = 0, m_err = 0, m_lvl = 0;
    int m_prev = 0, m_dir = 0, m_wait = 0;
    int g_reg = 0, g_pll = 0, g_dp = 0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic begin_up();
        if (m_reg == 0)      begin m_reg = 1; m_wait = int'(dly_reg); m_dir = 1; end
        else if (m_pll == 0) begin m_pll = 1; m_wait = int'(dly_pll); m_dir = 1; end
        else if (m_dp == 0)  begin m_dp = 1;  m_wait = int'(dly_dp);  m_dir = 1; end
        else begin m_dir = 0; m_ready = 1; end
    endtask

    task automatic begin_down();
        if (g_dp == 1 && m_dp == 1)        begin m_dp = 0;  m_wait = int'(dly_dp);  m_dir = 2; end
        else if (g_pll == 1 && m_pll == 1) begin m_pll = 0; m_wait = int'(dly_pll); m_dir = 2; end
        else if (g_reg == 1 && m_reg == 1) begin m_reg = 0; m_wait = int'(dly_reg); m_dir = 2; end
        else m_dir = 0;
    endtask

    task automatic model_step();
        int r, f, old_lvl;
        if (!rst_n) begin
            m_reg = 1; m_pll = 1; m_dp = 0; m_ready = 0; m_err = 0; m_lvl = 0;
            m_prev = 0; m_dir = 0; m_wait = 0;
            return;
        end
        r = (chan_en && m_prev == 0) ? 1 : 0;
        f = (!chan_en && m_prev == 1) ? 1 : 0;
        m_prev = chan_en ? 1 : 0;
        old_lvl = m_lvl;
        if (cfg_wr) begin
            if (int'(cfg_level) > 2) begin m_err = 1; m_lvl = 0; end
            else m_lvl = int'(cfg_level);
        end
        if (f == 1) begin
            m_ready = 0;
            g_dp = 1;
            g_pll = (old_lvl >= 1) ? 1 : 0;
            g_reg = (old_lvl >= 2) ? 1 : 0;
            begin_down();
        end else if (r == 1) begin
            m_ready = 0;
            begin_up();
        end else if (m_dir != 0) begin
            if (m_wait > 0) m_wait--;
            else if (m_dir == 1) begin_up();
            else begin_down();
        end
    endtask

    task automatic compare_all();
        chk(tag, "reg_en", int'(reg_en), m_reg);
        chk(tag, "pll_en", int'(pll_en), m_pll);
        chk(tag, "dp_en", int'(dp_en), m_dp);
        chk(tag, "ready", int'(ready), m_ready);
        chk(tag, "busy R11", int'(busy), (m_dir != 0) ? 1 : 0);
        chk(tag, "cfg_err", int'(cfg_err), m_err);
        chk(tag, "level_out", int'(level_out), m_lvl);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic write_level(int v);
        cfg_wr = 1'b1; cfg_level = v[1:0];
        tick();
        cfg_wr = 1'b0;
    endtask

    // Raises chan_en and counts ticks until ready is seen.
    task automatic rise_count(output int n);
        chan_en = 1'b1;
        n = 0;
        for (int i = 0; i < 100; i++) begin
            tick();
            n++;
            if (ready) break;
        end
    endtask

    initial begin
        int n;
        run(3);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        chk("R1", "reset reg_en", int'(reg_en), 1);
        chk("R1", "reset pll_en", int'(pll_en), 1);
        chk("R1", "reset dp_en", int'(dp_en), 0);
        chk("R1", "reset ready", int'(ready), 0);
        chk("R1", "reset busy", int'(busy), 0);
        chk("R1", "reset cfg_err", int'(cfg_err), 0);
        chk("R1", "reset level", int'(level_out), 0);

        tag = "R2";
        write_level(1);
        chk("R2", "level after write 1", int'(level_out), 1);
        write_level(0);
        chk("R2", "level after write 0", int'(level_out), 0);

        // Initial power-up: only the datapath is off
        tag = "R7";
        rise_count(n);
        chk("R7", "ticks to ready (dp only)", n, int'(dly_dp) + 2);

        // Level 0 power-down
        tag = "R8";
        chan_en = 1'b0;
        tick();
        chk("R8", "ready low at fall", int'(ready), 0);
        chk("R4", "dp off at level 0", int'(dp_en), 0);
        tag = "R4";
        run(10);
        chk("R4", "pll kept at level 0", int'(pll_en), 1);
        chk("R4", "reg kept at level 0", int'(reg_en), 1);
        rise_count(n);

        // Level 1 power-down: order and spacing
        tag = "R5";
        write_level(1);
        chan_en = 1'b0;
        tick();
        chk("R5", "dp off first", int'(dp_en), 0);
        run(2);
        chk("R5", "pll still on before dp delay", int'(pll_en), 1);
        tick();
        chk("R5", "pll off after dp delay", int'(pll_en), 0);
        run(10);
        chk("R4", "reg kept at level 1", int'(reg_en), 1);
        tag = "R6";
        rise_count(n);
        chk("R6", "ticks to ready level 1", n, int'(dly_pll) + int'(dly_dp) + 3);

        // Level 2 full cycle
        tag = "R4";
        write_level(2);
        chan_en = 1'b0;
        run(20);
        chk("R4", "all off at level 2", int'({reg_en, pll_en, dp_en}), 0);
        tag = "R6";
        rise_count(n);
        chk("R6", "ticks to ready level 2", n,
            int'(dly_reg) + int'(dly_pll) + int'(dly_dp) + 4);

        // Abort power-down with a rising edge
        tag = "R9";
        chan_en = 1'b0;
        run(2);
        chk("R11", "busy during power-down", int'(busy), 1);
        chan_en = 1'b1;
        tick();
        chk("R9", "dp back on at abort", int'(dp_en), 1);
        chk("R9", "reg never gated", int'(reg_en), 1);
        run(10);
        chk("R9", "ready after abort", int'(ready), 1);
        chk("R11", "idle after abort", int'(busy), 0);

        // Fall during power-up
        tag = "R10";
        chan_en = 1'b0;
        run(20);
        chan_en = 1'b1;
        run(5);
        chan_en = 1'b0;
        tick();
        chk("R10", "pll turned off again", int'(pll_en), 0);
        chk("R10", "ready low", int'(ready), 0);
        run(20);
        chk("R10", "all off after reversal", int'({reg_en, pll_en, dp_en}), 0);
        chk("R10", "ready stays low", int'(ready), 0);

        // Zero delays
        tag = "R6";
        dly_reg = 4'd0; dly_pll = 4'd0; dly_dp = 4'd0;
        rise_count(n);
        chk("R6", "ticks to ready zero delays", n, 4);
        chan_en = 1'b0;
        run(5);
        dly_reg = 4'd3; dly_pll = 4'd5; dly_dp = 4'd2;

        // Illegal level
        tag = "R3";
        write_level(3);
        chk("R3", "err after illegal", int'(cfg_err), 1);
        chk("R3", "level forced 0", int'(level_out), 0);
        write_level(1);
        chk("R3", "err sticky", int'(cfg_err), 1);
        chk("R3", "legal write after err", int'(level_out), 1);
        rise_count(n);
        chk("R7", "ready after final rise", int'(ready), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule